// File: doc/BRIEF.md
# Five-Channel Down-Counting Timer Bank

This block holds five independent down-counters behind a small synchronous register port. Each channel has a count buffer. Channels 0 to 3 also have a compare buffer. Software writes the buffers and raises a per-channel update bit to copy them into the live counter and compare registers. It then clears update and sets run in a single control write.

While running, a channel counts down by one on every cycle where its tick-enable input is high. When the count is zero on a tick, the channel does one of two things. It reloads from its count buffer if auto-reload is set. Otherwise it stops and holds zero.

Every zero-on-tick event sets the channel's pending flag. The interrupt output for a channel is its pending flag ANDed with its enable. Software clears a pending flag by writing one to it. The live count of each channel can be read at an observation address. Channels 0 to 3 also drive a level output, which is high while the live count is at or below the live compare value and is optionally inverted.

Top module: `timer_bank`

## Requirements
- R1: After reset, every register reads zero, `irq` is zero, and `wave_out` is all ones, because a zero count is at or below a zero compare value.
- R2: Count buffers sit at 0x0C+12n for channels 0–4, and compare buffers sit at 0x10+12n for channels 0–3. A buffer keeps the low CNT_W bits of a write, and the bits above CNT_W read zero. Addresses that are not mapped read zero.
- R3: The control register sits at 0x08. Channel 0 owns bits [3:0], and channel n≥1 owns bits [4n+7:4n+4]. Bits [7:4], bit 23 and bits [31:24] ignore writes and read zero. Writing all ones therefore reads back 0x007FFF0F.
- R4: In each field, bit +1 is the update bit. While update is set, the live counter and live compare value are loaded from the buffers on every clock. Any earlier one-shot stop is also cancelled.
- R5: In each field, bit +0 is run. A running channel that is not updating decrements by exactly one on each cycle its `tick_en` bit is high. When `tick_en` is low, or run is clear, the count stays frozen.
- R6: With auto-reload set (bit +3 for channels 0–3), a count of zero on a tick reloads the count buffer. A buffer value N gives a period of N+1 ticks.
- R7: With auto-reload clear, a count of zero on a tick stops the channel at zero. It stays stopped until the next update.
- R8: Channel 4 has its control field at bits [23:20], with run at bit 20, update at bit 21 and auto-reload at bit 22. It has no compare buffer and no invert. Its live count is observed at 0x40. The live count of channel n<4 is observed at 0x14+12n.
- R9: The interrupt register sits at 0x44. Bits [4:0] are the enables, and bits [9:5] are the pending flags. A zero-on-tick event sets the channel's pending flag. Writing 1 to a pending bit clears it, and a new event in the same cycle wins over the clear. `irq[n]` equals pending[n] AND enable[n].
- R10: For channel n<4, `wave_out[n]` equals (live count ≤ live compare) XOR the invert bit, which is bit +2 of the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_en | input | 5 | Per-channel count enable from the prescaler |
| irq | output | 5 | Per-channel interrupt, pending AND enable |
| wave_out | output | 4 | Compare-match level for channels 0–3 |

## Verification
The hardest case to reach is the zero-on-tick boundary, where auto-reload and one-shot behaviour split and the pending flag is set. It is reached only after a full update-then-run control sequence and an exact number of ticks. The bench loads small count values, between 1 and 3, so this edge comes within a few cycles. It then follows the live count cycle by cycle against a reference sequence that wraps N, …, 0, N. The shifted last field is driven the same way through its own bit positions. This shows that its auto-reload bit at +2 and its observation address at 0x40 are decoded.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

   localparam int TB_NUM_CH  = 5;
   localparam int TB_NUM_CMP = 4;

   localparam logic [7:0] TB_ADDR_CTL      = 8'h08;
   localparam logic [7:0] TB_ADDR_IRQ      = 8'h44;
   localparam logic [7:0] TB_ADDR_OBS_LAST = 8'h40;

   typedef struct packed {
      logic run;
      logic upd;
      logic inv;
      logic rel;
   } ctl_field_t;

   function automatic logic [7:0] cnt_buf_addr(input int ch);
      return 8'(12 + 12 * ch);
   endfunction

   function automatic logic [7:0] cmp_buf_addr(input int ch);
      return 8'(16 + 12 * ch);
   endfunction

   function automatic logic [7:0] obs_addr(input int ch);
      return (ch == TB_NUM_CH - 1) ? TB_ADDR_OBS_LAST : 8'(20 + 12 * ch);
   endfunction

   function automatic int ctl_base(input int ch);
      return (ch == 0) ? 0 : 4 * (ch + 1);
   endfunction

endpackage

// File: rtl/timer_ctl_reg.sv
module timer_ctl_reg
   import timer_bank_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [31:0]                   wdata,
   output ctl_field_t [TB_NUM_CH-1:0]    fld,
   output logic [31:0]                   rdata
);

   ctl_field_t [TB_NUM_CH-1:0] fld_q;
   logic [TB_NUM_CH-1:0][3:0]  rd_part;

   for (genvar ch = 0; ch < TB_NUM_CH; ch++) begin : g_fld
      localparam int BASE = ctl_base(ch);
      if (ch == TB_NUM_CH - 1) begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fld_q[ch] <= '0;
            end else if (wr) begin
               fld_q[ch].run <= wdata[BASE];
               fld_q[ch].upd <= wdata[BASE+1];
               fld_q[ch].rel <= wdata[BASE+2];
               fld_q[ch].inv <= 1'b0;
            end
         end
         assign rd_part[ch] = {1'b0, fld_q[ch].rel, fld_q[ch].upd, fld_q[ch].run};
      end else begin : g_std
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fld_q[ch] <= '0;
            end else if (wr) begin
               fld_q[ch].run <= wdata[BASE];
               fld_q[ch].upd <= wdata[BASE+1];
               fld_q[ch].inv <= wdata[BASE+2];
               fld_q[ch].rel <= wdata[BASE+3];
            end
         end
         assign rd_part[ch] = {fld_q[ch].rel, fld_q[ch].inv, fld_q[ch].upd, fld_q[ch].run};
      end
   end

   always_comb begin
      rdata = '0;
      for (int ch = 0; ch < TB_NUM_CH; ch++) begin
         rdata[ctl_base(ch) +: 4] = rd_part[ch];
      end
   end

   assign fld = fld_q;

   a_r3_last_no_invert: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !fld_q[TB_NUM_CH-1].inv);

endmodule

// File: rtl/timer_chan.sv
module timer_chan
   import timer_bank_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit HAS_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  ctl_field_t       fld,
   input  logic             wr_cnt,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt_buf,
   output logic [CNT_W-1:0] cmp_buf,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt,
   output logic             wave
);

   logic             expired;
   logic [CNT_W-1:0] cnt_buf_q;
   logic [CNT_W-1:0] count_q;
   logic             active;

   assign active   = fld.run && !fld.upd && tick && !expired;
   assign zero_evt = active && (count_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_buf_q <= '0;
         count_q   <= '0;
         expired   <= 1'b0;
      end else begin
         if (wr_cnt) cnt_buf_q <= wdata;
         if (fld.upd) begin
            count_q <= cnt_buf_q;
            expired <= 1'b0;
         end else if (active) begin
            if (count_q == '0) begin
               if (fld.rel) count_q <= cnt_buf_q;
               else         expired <= 1'b1;
            end else begin
               count_q <= count_q - 1'b1;
            end
         end
      end
   end

   if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_buf_q;
      logic [CNT_W-1:0] cmp_act_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
         end else begin
            if (wr_cmp)  cmp_buf_q <= wdata;
            if (fld.upd) cmp_act_q <= cmp_buf_q;
         end
      end
      assign cmp_buf = cmp_buf_q;
      assign wave    = (count_q <= cmp_act_q) ^ fld.inv;

      a_r4_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
         fld.upd |=> cmp_act_q == $past(cmp_buf_q));
   end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = wr_cmp ^ fld.inv;
      assign cmp_buf    = '0;
      assign wave       = 1'b0;
   end

   assign cnt_buf = cnt_buf_q;
   assign count   = count_q;

   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      fld.upd |=> count_q == $past(cnt_buf_q));
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fld.run && !fld.upd && tick && !expired && count_q != '0)
      |=> count_q == $past(count_q) - 1'b1);
   a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!fld.upd && (!fld.run || !tick)) |=> $stable(count_q));
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && fld.rel) |=> count_q == $past(cnt_buf_q));
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !fld.upd) |=> (count_q == '0) && !zero_evt);

endmodule

// File: rtl/timer_irq_reg.sv
module timer_irq_reg #(
   parameter int NUM_CH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2*NUM_CH-1:0] wdata,
   input  logic [NUM_CH-1:0] evt,
   output logic [NUM_CH-1:0] en,
   output logic [NUM_CH-1:0] pend,
   output logic [NUM_CH-1:0] irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= '0;
         pend <= '0;
      end else begin
         if (wr) en <= wdata[NUM_CH-1:0];
         pend <= evt | (pend & ~(wr ? wdata[2*NUM_CH-1:NUM_CH] : '0));
      end
   end

   assign irq = pend & en;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> pend[i]);
      a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && wdata[NUM_CH+i] && !evt[i]) |=> !pend[i]);
      a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr && !evt[i]) |=> $stable(pend[i]));
   end

endmodule

// File: rtl/timer_bank.sv
module timer_bank
   import timer_bank_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [4:0]        tick_en,
   output logic [4:0]        irq,
   output logic [3:0]        wave_out
);

   localparam int NCH  = TB_NUM_CH;
   localparam int NCMP = TB_NUM_CMP;

   if (CNT_W < 16 || CNT_W > 32) begin : g_bad_width
      $error("timer_bank: CNT_W must lie in 16..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("timer_bank: ADDR_W must be at least 7");
   end

   ctl_field_t [NCH-1:0] fld;
   logic [31:0]          ctl_rd;
   logic [NCH-1:0]       zero_evt;
   logic [NCH-1:0]       irq_en;
   logic [NCH-1:0]       irq_pend;
   logic [NCH-1:0]       wave_all;
   logic [CNT_W-1:0]     cnt_buf [NCH];
   logic [CNT_W-1:0]     cmp_buf [NCH];
   logic [CNT_W-1:0]     count   [NCH];
   logic                 wr_ctl, wr_irq;

   assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(TB_ADDR_CTL));
   assign wr_irq = bus_wr && (bus_addr == ADDR_W'(TB_ADDR_IRQ));

   timer_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ctl),
      .wdata (bus_wdata),
      .fld   (fld),
      .rdata (ctl_rd)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic wr_cnt, wr_cmp;
      assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(cnt_buf_addr(ch)));
      assign wr_cmp = (ch < NCMP) && bus_wr && (bus_addr == ADDR_W'(cmp_buf_addr(ch)));

      timer_chan #(
         .CNT_W   (CNT_W),
         .HAS_CMP (ch < NCMP)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick_en[ch]),
         .fld      (fld[ch]),
         .wr_cnt   (wr_cnt),
         .wr_cmp   (wr_cmp),
         .wdata    (bus_wdata[CNT_W-1:0]),
         .cnt_buf  (cnt_buf[ch]),
         .cmp_buf  (cmp_buf[ch]),
         .count    (count[ch]),
         .zero_evt (zero_evt[ch]),
         .wave     (wave_all[ch])
      );
   end

   timer_irq_reg #(.NUM_CH(NCH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_irq),
      .wdata (bus_wdata[2*NCH-1:0]),
      .evt   (zero_evt),
      .en    (irq_en),
      .pend  (irq_pend),
      .irq   (irq)
   );

   assign wave_out = wave_all[NCMP-1:0];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(TB_ADDR_CTL)) bus_rdata = ctl_rd;
      if (bus_addr == ADDR_W'(TB_ADDR_IRQ)) bus_rdata = 32'({irq_pend, irq_en});
      for (int ch = 0; ch < NCH; ch++) begin
         if (bus_addr == ADDR_W'(cnt_buf_addr(ch))) bus_rdata = 32'(cnt_buf[ch]);
         if (ch < NCMP && bus_addr == ADDR_W'(cmp_buf_addr(ch))) bus_rdata = 32'(cmp_buf[ch]);
         if (bus_addr == ADDR_W'(obs_addr(ch))) bus_rdata = 32'(count[ch]);
      end
   end

   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_irq |=> (irq & ~$past(bus_wdata[NCH-1:0])) == '0);

endmodule

// File: tb/timer_bank_tb_top.sv
module timer_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  tick_en = 5'h1F;
   logic [4:0]  irq;
   logic [3:0]  wave_out;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   timer_bank #(.CNT_W(16), .ADDR_W(8)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_en   (tick_en),
      .irq       (irq),
      .wave_out  (wave_out)
   );

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
         finish_run();
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h08, v); check("R1 ctl", v, 0);
      rd(8'h44, v); check("R1 irq reg", v, 0);
      rd(8'h14, v); check("R1 obs0", v, 0);
      rd(8'h40, v); check("R1 obs4", v, 0);
      check("R1 irq pin", 32'(irq), 0);
      check("R1 wave", 32'(wave_out), 32'hF);
   endtask

   task automatic t_buffers();
      logic [31:0] v;
      wr(8'h18, 32'h0001_2345);
      rd(8'h18, v); check("R2 cnt1 trunc", v, 32'h2345);
      wr(8'h1C, 32'hFFFF_ABCD);
      rd(8'h1C, v); check("R2 cmp1", v, 32'hABCD);
      wr(8'h30, 32'h0000_0777);
      rd(8'h30, v); check("R2 cnt3", v, 32'h0777);
      rd(8'h04, v); check("R2 unmapped", v, 0);
   endtask

   task automatic t_ctl_layout();
      logic [31:0] v;
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, v); check("R3 layout", v, 32'h007F_FF0F);
      wr(8'h08, 32'h0000_00F0);
      rd(8'h08, v); check("R3 gap ignored", v, 0);
   endtask

   task automatic t_autoreload();
      logic [31:0] v;
      int e;
      wr(8'h18, 32'd3);
      wr(8'h08, 32'h0000_0200);
      step(1);
      rd(8'h20, v); check("R4 load", v, 3);
      wr(8'h08, 32'h0000_0900);
      e = 3;
      rd(8'h20, v); check("R6 start", v, 32'(e));
      for (int k = 0; k < 8; k++) begin
         step(1);
         e = (e == 0) ? 3 : e - 1;
         rd(8'h20, v); check("R6 sequence", v, 32'(e));
      end
   endtask

   task automatic t_freeze();
      logic [31:0] v, w;
      tick_en[1] = 1'b0;
      rd(8'h20, v);
      step(3);
      rd(8'h20, w); check("R5 tick gate", w, v);
      tick_en[1] = 1'b1;
      wr(8'h08, 32'h0000_0800);
      rd(8'h20, v);
      step(3);
      rd(8'h20, w); check("R5 run clear", w, v);
   endtask

   task automatic t_oneshot();
      logic [31:0] v;
      wr(8'h08, 32'h0);
      wr(8'h44, 32'h3E0);
      rd(8'h44, v); check("R9 cleared", v, 0);
      wr(8'h0C, 32'd2);
      wr(8'h08, 32'h2);
      step(1);
      wr(8'h08, 32'h1);
      rd(8'h14, v); check("R7 start", v, 2);
      step(1); rd(8'h14, v); check("R7 count", v, 1);
      step(1); rd(8'h14, v); check("R7 count", v, 0);
      step(1); rd(8'h14, v); check("R7 stop", v, 0);
      step(3); rd(8'h14, v); check("R7 held", v, 0);
      rd(8'h44, v); check("R9 pending once", v, 32'h20);
      check("R9 irq masked", 32'(irq), 0);
      wr(8'h44, 32'h01);
      check("R9 irq raised", 32'(irq), 1);
      rd(8'h44, v); check("R9 enable kept", v, 32'h21);
      wr(8'h44, 32'h21);
      check("R9 irq cleared", 32'(irq), 0);
      rd(8'h44, v); check("R9 w1c", v, 32'h01);
   endtask

   task automatic t_last();
      logic [31:0] v;
      int e;
      wr(8'h44, 32'h3E0);
      wr(8'h3C, 32'd1);
      rd(8'h3C, v); check("R8 cnt4 buf", v, 1);
      wr(8'h08, 32'h0020_0000);
      step(1);
      wr(8'h08, 32'h0050_0000);
      rd(8'h08, v); check("R8 field", v, 32'h0050_0000);
      e = 1;
      rd(8'h40, v); check("R8 obs", v, 32'(e));
      for (int k = 0; k < 4; k++) begin
         step(1);
         e = (e == 0) ? 1 : 0;
         rd(8'h40, v); check("R8 reload", v, 32'(e));
      end
      rd(8'h44, v); check("R8 pending4", v, 32'h200);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_compare();
      logic [31:0] v;
      wr(8'h24, 32'd5);
      wr(8'h28, 32'd2);
      wr(8'h08, 32'h0000_2000);
      step(1);
      check("R10 above", 32'(wave_out[2]), 0);
      wr(8'h24, 32'd1);
      step(1);
      rd(8'h2C, v); check("R10 obs2", v, 1);
      check("R10 below", 32'(wave_out[2]), 1);
      wr(8'h08, 32'h0000_6000);
      check("R10 invert", 32'(wave_out[2]), 0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_buffers();
      t_ctl_layout();
      t_autoreload();
      t_freeze();
      t_oneshot();
      t_last();
      t_compare();
      finish_run();
   end

endmodule